// File: doc/BRIEF.md
# Shift-Register Handshake Link Controller

This block is the host end of a half-duplex byte link to a peripheral microcontroller. Bytes move through an external 8-bit shift register. Three handshake lines frame them. The host drives a transfer-in-progress line (`tip_n`, active low) and a byte-acknowledge line (`ack`). The peripheral drives an active-low request line (`req_n`). The controller sends one framed packet from a small outbound buffer. It captures inbound frames into a receive buffer. It paces every line change that needs a settling time with a single shared down-counter.

Both sides may try to start a frame at the same moment. The peripheral always wins. If the request line is low when a write byte completes, the write is abandoned and the lines go back to idle levels. After a short settling wait the host takes the inbound frame. A long gap follows the end of that frame. The write then restarts from byte zero, unless the peripheral has asked for the link again by then.

After reset the controller runs a fixed line sequence to resynchronise the peripheral before it accepts any traffic. The user writes packet bytes into the outbound buffer and pulses `tx_start` with a length. `tx_busy` stays high until the last byte has shifted out. Each inbound frame is announced by a one-cycle `rx_done` pulse. With that pulse come the frame's type byte, its payload count and an overflow flag. The payload can then be read back by index.

Top module: `shreg_link_ctrl`

## Requirements
- R1: While reset is applied, and again whenever the link is idle, `tip_n`=1, `ack`=1, `sr_dir_out`=0 (input direction) and `tx_busy`=0 (no write pending), and `sr_load` stays 0.
- R2: After reset is released, the lines change in this order, with at least SETTLE_US*CLK_MHZ cycles before each change: `tip_n` falls, `ack` inverts, `tip_n` rises, `ack` returns to 1.
- R3: Suppose a write is accepted while idle and `req_n`=1. The controller waits at least SETTLE_US*CLK_MHZ cycles. It then drives `sr_dir_out`=1, pulses `sr_load` with buffer byte 0, and holds `ack`=1 and `tip_n`=0.
- R4: During a write, each `sr_done` with `req_n`=1 loads the next buffer byte and inverts `ack`. After `tx_len` completed bytes there is no further load, the lines return to idle levels and `tx_busy` falls.
- R5: Suppose `sr_done` arrives during a write with `req_n`=0. The write is abandoned: no further load, idle line levels, input direction, and `tx_busy` stays 1. After the settling time `tip_n` goes low to receive, with no further `sr_done` needed.
- R6: In idle, `sr_done` with `req_n`=0 discards that first byte and starts a receive (`tip_n`=0, input direction). In idle, `sr_done` with `req_n`=1 and no write pending is ignored: the lines do not change and nothing is delivered.
- R7: During a receive, each `sr_done` stores `sr_rd_data`. `ack` inverts while `req_n`=0. The byte that arrives with `req_n`=1 is the last one. The lines then return to idle and `rx_done` pulses for one cycle. `rx_type` is the first stored byte and `rx_len` is the stored byte count minus one. Payload byte k is presented on `rx_rd_data` when `rx_rd_addr`=k.
- R8: A frame that reaches RX_DEPTH stored bytes with `req_n` still 0 ends there. It is delivered with `rx_ovf`=1 and `rx_len`=RX_DEPTH-1. The next delivered frame carries `rx_ovf`=0.
- R9: If a write is pending when an inbound frame ends, the write restarts at byte 0 no sooner than GAP_US*CLK_MHZ cycles after the frame end. If `req_n`=0 when that wait expires, no byte is loaded. The next `sr_done` then starts a receive.
- R10: `tx_start` is ignored while `tx_busy`=1, and also when `tx_len` is 0 or above TX_DEPTH.
- R11: `rx_type`, `rx_len` and `rx_ovf` change only in the cycle in which `rx_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the line sequence |
| tx_wr_en | input | 1 | Write strobe for the outbound buffer |
| tx_wr_addr | input | $clog2(TX_DEPTH) | Outbound buffer byte index |
| tx_wr_data | input | 8 | Outbound buffer byte |
| tx_start | input | 1 | Request to send `tx_len` bytes from the buffer |
| tx_len | input | $clog2(TX_DEPTH+1) | Outbound frame length in bytes |
| tx_busy | output | 1 | A write is pending or in progress |
| rx_done | output | 1 | One-cycle pulse: an inbound frame was delivered |
| rx_type | output | 8 | First byte of the delivered frame |
| rx_len | output | $clog2(RX_DEPTH) | Payload byte count of the delivered frame |
| rx_ovf | output | 1 | Delivered frame was cut at the buffer limit |
| rx_rd_addr | input | $clog2(RX_DEPTH) | Payload byte index to read |
| rx_rd_data | output | 8 | Payload byte at `rx_rd_addr` |
| sr_dir_out | output | 1 | Shift register direction, 1 = output |
| sr_load | output | 1 | Load `sr_load_data` into the shift register |
| sr_load_data | output | 8 | Byte to shift out |
| sr_rd_data | input | 8 | Byte shifted in |
| sr_done | input | 1 | One-cycle strobe: a byte finished shifting |
| tip_n | output | 1 | Transfer-in-progress, active low |
| ack | output | 1 | Byte acknowledge; inverts once per byte |
| req_n | input | 1 | Peripheral request, active low |

## Verification
The write path is tried in three ways: with a clear request line, with the request line raised after the first byte, and with the write queued while a request is already pending. Together these separate a normal frame end from a mid-frame abort and from a start that is deferred behind a read. The read path is tried with a type-only frame, a frame with a short payload, and a frame held open past the buffer limit. These show the length arithmetic and the one-frame scope of the overflow flag. Line-change spacing is measured in cycles at the pins: through the reset sequence, from `tx_start` to the first load, and from a frame end to the restarted write. A request raised inside the gap shows that the timer expiry hands the link to the peripheral and does not force a write.

// File: rtl/link_pkg.sv
package link_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        L_RST0, L_RST1, L_RST2, L_RST3,
        L_IDLE, L_PREP, L_OUT, L_IN, L_GAP, L_ABRT
    } link_st_e;

    typedef enum logic {
        DLY_SETTLE,
        DLY_GAP
    } dly_sel_e;

    typedef struct packed {
        logic tip_n;
        logic ack;
        logic dir_out;
    } line_t;

    localparam line_t LINES_IDLE = '{tip_n: 1'b1, ack: 1'b1, dir_out: 1'b0};
    localparam line_t LINES_RX   = '{tip_n: 1'b0, ack: 1'b1, dir_out: 1'b0};
    localparam line_t LINES_TX   = '{tip_n: 1'b0, ack: 1'b1, dir_out: 1'b1};

    function automatic int unsigned us_cycles(input int unsigned us, input int unsigned mhz);
        return us * mhz;
    endfunction

endpackage

// File: rtl/link_delay.sv
module link_delay
    import link_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 100,
    parameter int unsigned SETTLE_US = 150,
    parameter int unsigned GAP_US    = 1500
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  dly_sel_e sel,
    output logic     zero
);
    localparam int unsigned SETTLE_CYC = us_cycles(SETTLE_US, CLK_MHZ);
    localparam int unsigned GAP_CYC    = us_cycles(GAP_US, CLK_MHZ);
    localparam int unsigned MAX_CYC    = (GAP_CYC > SETTLE_CYC) ? GAP_CYC : SETTLE_CYC;
    localparam int CW = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CW'(SETTLE_CYC);
        end else if (load) begin
            cnt <= (sel == DLY_GAP) ? CW'(GAP_CYC) : CW'(SETTLE_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    AST_DLY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R9

endmodule

// File: rtl/link_buf.sv
module link_buf
    import link_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/shreg_link_ctrl.sv
module shreg_link_ctrl
    import link_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 100,
    parameter int unsigned SETTLE_US = 150,
    parameter int unsigned GAP_US    = 1500,
    parameter int TX_DEPTH = 16,
    parameter int RX_DEPTH = 256,
    localparam int TXAW = $clog2(TX_DEPTH),
    localparam int TXLW = $clog2(TX_DEPTH + 1),
    localparam int RXAW = $clog2(RX_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_wr_en,
    input  logic [TXAW-1:0]   tx_wr_addr,
    input  logic [BYTE_W-1:0] tx_wr_data,
    input  logic              tx_start,
    input  logic [TXLW-1:0]   tx_len,
    output logic              tx_busy,
    output logic              rx_done,
    output logic [BYTE_W-1:0] rx_type,
    output logic [RXAW-1:0]   rx_len,
    output logic              rx_ovf,
    input  logic [RXAW-1:0]   rx_rd_addr,
    output logic [BYTE_W-1:0] rx_rd_data,
    output logic              sr_dir_out,
    output logic              sr_load,
    output logic [BYTE_W-1:0] sr_load_data,
    input  logic [BYTE_W-1:0] sr_rd_data,
    input  logic              sr_done,
    output logic              tip_n,
    output logic              ack,
    input  logic              req_n
);
    localparam logic [RXAW-1:0] RX_LAST = RXAW'(RX_DEPTH - 1);

    link_st_e          st;
    line_t             lines;
    logic [TXLW-1:0]   frame_len;
    logic [TXLW-1:0]   sent;
    logic [TXLW-1:0]   sent_nx;
    logic [RXAW-1:0]   cnt;
    logic [BYTE_W-1:0] type_sh;
    logic [BYTE_W-1:0] tx_byte;
    logic [TXAW-1:0]   tx_raddr;
    logic              tmr_load;
    dly_sel_e          tmr_sel;
    logic              tmr_zero;
    logic              rx_last;
    logic              rx_we;

    assign tip_n      = lines.tip_n;
    assign ack        = lines.ack;
    assign sr_dir_out = lines.dir_out;
    assign sent_nx    = sent + 1'b1;
    assign tx_raddr   = (st == L_OUT) ? sent_nx[TXAW-1:0] : '0;
    assign rx_last    = req_n || (cnt == RX_LAST);
    assign rx_we      = (st == L_IN) && sr_done;

    link_delay #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US), .GAP_US(GAP_US)) u_delay (
        .clk(clk), .rst(rst), .load(tmr_load), .sel(tmr_sel), .zero(tmr_zero)
    );

    link_buf #(.DEPTH(TX_DEPTH)) u_txbuf (
        .clk(clk), .we(tx_wr_en), .waddr(tx_wr_addr), .wdata(tx_wr_data),
        .raddr(tx_raddr), .rdata(tx_byte)
    );

    link_buf #(.DEPTH(RX_DEPTH)) u_rxbuf (
        .clk(clk), .we(rx_we), .waddr(cnt), .wdata(sr_rd_data),
        .raddr(RXAW'(rx_rd_addr + 1'b1)), .rdata(rx_rd_data)
    );

    // Timer reload requests: one counter serves every wait.
    always_comb begin
        tmr_load = 1'b0;
        tmr_sel  = DLY_SETTLE;
        unique case (st)
            L_RST0, L_RST1, L_RST2: tmr_load = tmr_zero;
            L_IDLE: tmr_load = !(sr_done && !req_n) && tx_busy && req_n;
            L_OUT:  tmr_load = sr_done && !req_n;
            L_IN: begin
                if (sr_done && rx_last && tx_busy) begin
                    tmr_load = 1'b1;
                    tmr_sel  = DLY_GAP;
                end
            end
            default: tmr_load = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= L_RST0;
            lines        <= LINES_IDLE;
            sr_load      <= 1'b0;
            sr_load_data <= '0;
            tx_busy      <= 1'b0;
            frame_len    <= '0;
            sent         <= '0;
            cnt          <= '0;
            type_sh      <= '0;
            rx_done      <= 1'b0;
            rx_type      <= '0;
            rx_len       <= '0;
            rx_ovf       <= 1'b0;
        end else begin
            sr_load <= 1'b0;
            rx_done <= 1'b0;
            if (tx_start && !tx_busy && tx_len != '0 && tx_len <= TXLW'(TX_DEPTH)) begin
                tx_busy   <= 1'b1;
                frame_len <= tx_len;
            end
            unique case (st)
                L_RST0: if (tmr_zero) begin lines.tip_n <= 1'b0;       st <= L_RST1; end
                L_RST1: if (tmr_zero) begin lines.ack   <= ~lines.ack; st <= L_RST2; end
                L_RST2: if (tmr_zero) begin lines.tip_n <= 1'b1;       st <= L_RST3; end
                L_RST3: if (tmr_zero) begin lines <= LINES_IDLE;       st <= L_IDLE; end
                L_IDLE: begin
                    if (sr_done && !req_n) begin
                        lines <= LINES_RX;
                        cnt   <= '0;
                        st    <= L_IN;
                    end else if (tx_busy && req_n) begin
                        st <= L_PREP;
                    end
                end
                L_PREP, L_GAP: begin
                    if (tmr_zero) begin
                        if (req_n) begin
                            lines        <= LINES_TX;
                            sr_load      <= 1'b1;
                            sr_load_data <= tx_byte;
                            sent         <= '0;
                            st           <= L_OUT;
                        end else begin
                            st <= L_IDLE;
                        end
                    end
                end
                L_OUT: begin
                    if (sr_done) begin
                        if (!req_n) begin
                            lines <= LINES_IDLE;
                            sent  <= '0;
                            st    <= L_ABRT;
                        end else if (sent_nx == frame_len) begin
                            lines   <= LINES_IDLE;
                            tx_busy <= 1'b0;
                            st      <= L_IDLE;
                        end else begin
                            sr_load      <= 1'b1;
                            sr_load_data <= tx_byte;
                            lines.ack    <= ~lines.ack;
                            sent         <= sent_nx;
                        end
                    end
                end
                L_ABRT: begin
                    if (tmr_zero) begin
                        lines <= LINES_RX;
                        cnt   <= '0;
                        st    <= L_IN;
                    end
                end
                L_IN: begin
                    if (sr_done) begin
                        if (cnt == '0) type_sh <= sr_rd_data;
                        if (rx_last) begin
                            lines   <= LINES_IDLE;
                            rx_done <= 1'b1;
                            rx_len  <= cnt;
                            rx_ovf  <= !req_n;
                            rx_type <= (cnt == '0) ? sr_rd_data : type_sh;
                            st      <= tx_busy ? L_GAP : L_IDLE;
                        end else begin
                            lines.ack <= ~lines.ack;
                            cnt       <= cnt + 1'b1;
                        end
                    end
                end
                default: st <= L_IDLE;
            endcase
        end
    end

    AST_IDLE_INPUT_DIR: assert property (@(posedge clk) disable iff (rst)
        (st == L_IDLE) |-> (tip_n && !sr_dir_out && !sr_load)); // R1

    AST_LOAD_NEEDS_OUT: assert property (@(posedge clk) disable iff (rst)
        sr_load |-> (sr_dir_out && !tip_n)); // R3

    AST_ACK_FLIPS_PER_BYTE: assert property (@(posedge clk) disable iff (rst)
        (sr_load && st == L_OUT && $past(st) == L_OUT) |-> (ack != $past(ack))); // R4

    AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (st == L_OUT && sr_done && !req_n) |=> (tip_n && !sr_dir_out && !sr_load && tx_busy)); // R5

    AST_RX_LINES: assert property (@(posedge clk) disable iff (rst)
        (st == L_IN) |-> (!tip_n && !sr_dir_out)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (st == L_IN && sr_done && cnt == RX_LAST) |=> (rx_done && tip_n)); // R8

    AST_DELIVERY_STABLE: assert property (@(posedge clk) disable iff (rst)
        !rx_done |-> ($stable(rx_ovf) && $stable(rx_len) && $stable(rx_type))); // R11

endmodule

// File: tb/tb_shreg_link_ctrl.sv
`timescale 1ns/1ps
module tb_shreg_link_ctrl;
    localparam int unsigned CLK_MHZ = 2;
    localparam int unsigned SET_US  = 3;
    localparam int unsigned GAP_US  = 10;
    localparam int TXD = 4;
    localparam int RXD = 8;
    localparam int SET_CYC = SET_US * CLK_MHZ;
    localparam int GAP_CYC = GAP_US * CLK_MHZ;
    localparam int TXAW = $clog2(TXD);
    localparam int TXLW = $clog2(TXD + 1);
    localparam int RXAW = $clog2(RXD);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_wr_en = 1'b0;
    logic [TXAW-1:0] tx_wr_addr = '0;
    logic [7:0] tx_wr_data = '0;
    logic tx_start = 1'b0;
    logic [TXLW-1:0] tx_len = '0;
    logic tx_busy, rx_done, rx_ovf;
    logic [7:0] rx_type;
    logic [RXAW-1:0] rx_len;
    logic [RXAW-1:0] rx_rd_addr = '0;
    logic [7:0] rx_rd_data;
    logic sr_dir_out, sr_load;
    logic [7:0] sr_load_data;
    logic [7:0] sr_rd_data = '0;
    logic sr_done = 1'b0;
    logic tip_n, ack;
    logic req_n = 1'b1;

    int nchk = 0;
    int nerr = 0;
    int load_cnt = 0;
    int rxd_cnt = 0;
    logic [7:0] last_load = '0;

    always #2.5 clk = ~clk;

    shreg_link_ctrl #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SET_US), .GAP_US(GAP_US),
                      .TX_DEPTH(TXD), .RX_DEPTH(RXD)) dut (
        .clk(clk), .rst(rst), .tx_wr_en(tx_wr_en), .tx_wr_addr(tx_wr_addr),
        .tx_wr_data(tx_wr_data), .tx_start(tx_start), .tx_len(tx_len),
        .tx_busy(tx_busy), .rx_done(rx_done), .rx_type(rx_type), .rx_len(rx_len),
        .rx_ovf(rx_ovf), .rx_rd_addr(rx_rd_addr), .rx_rd_data(rx_rd_data),
        .sr_dir_out(sr_dir_out), .sr_load(sr_load), .sr_load_data(sr_load_data),
        .sr_rd_data(sr_rd_data), .sr_done(sr_done), .tip_n(tip_n), .ack(ack),
        .req_n(req_n)
    );

    always @(posedge clk) begin
        if (!rst && sr_load) begin
            load_cnt  <= load_cnt + 1;
            last_load <= sr_load_data;
        end
        if (!rst && rx_done) rxd_cnt <= rxd_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lim);
        nchk++;
        if (act < lim) begin
            nerr++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
        end
    endtask

    task automatic pulse_done(input logic [7:0] d);
        sr_rd_data = d;
        sr_done = 1'b1;
        @(negedge clk);
        sr_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_load(output int waited);
        int base = load_cnt;
        waited = 0;
        while (load_cnt == base && waited < 500) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic wait_tip(input logic lvl, output int waited);
        waited = 0;
        while (tip_n != lvl && waited < 500) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic wait_ack(input logic lvl, output int waited);
        waited = 0;
        while (ack != lvl && waited < 500) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic start_tx(input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input int n);
        logic [7:0] bytes [3];
        bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
        for (int i = 0; i < 3; i++) begin
            tx_wr_en = 1'b1;
            tx_wr_addr = TXAW'(i);
            tx_wr_data = bytes[i];
            @(negedge clk);
        end
        tx_wr_en = 1'b0;
        tx_len = TXLW'(n);
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    task automatic test_reset();
        int w;
        chk("R1 tip_n in reset", tip_n, 1);
        chk("R1 ack in reset", ack, 1);
        chk("R1 dir in reset", sr_dir_out, 0);
        chk("R1 busy in reset", tx_busy, 0);
        @(negedge clk);
        rst = 1'b0;
        wait_tip(1'b0, w);
        chk_ge("R2 gap before tip fall", w, SET_CYC);
        chk("R2 ack high at tip fall", ack, 1);
        wait_ack(1'b0, w);
        chk_ge("R2 gap before ack flip", w, SET_CYC);
        chk("R2 tip low at ack flip", tip_n, 0);
        wait_tip(1'b1, w);
        chk_ge("R2 gap before tip rise", w, SET_CYC);
        chk("R2 ack low at tip rise", ack, 0);
        wait_ack(1'b1, w);
        chk_ge("R2 gap before ack restore", w, SET_CYC);
        repeat (3) @(negedge clk);
        chk("R1 idle tip_n", tip_n, 1);
        chk("R1 idle dir", sr_dir_out, 0);
        chk("R1 no load in reset sequence", load_cnt, 0);
    endtask

    task automatic test_write();
        int w;
        int base;
        start_tx(8'h11, 8'h22, 8'h33, 3);
        wait_load(w);
        chk_ge("R3 settle before first load", w, SET_CYC - 1);
        chk("R3 byte0", last_load, 8'h11);
        chk("R3 tip low", tip_n, 0);
        chk("R3 ack high", ack, 1);
        chk("R3 dir out", sr_dir_out, 1);
        chk("R3 busy", tx_busy, 1);
        tx_len = TXLW'(1);
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        pulse_done(8'h00);
        chk("R4 byte1", last_load, 8'h22);
        chk("R4 ack inverted 1", ack, 0);
        chk("R10 restart while busy ignored", load_cnt, 2);
        pulse_done(8'h00);
        chk("R4 byte2", last_load, 8'h33);
        chk("R4 ack inverted 2", ack, 1);
        base = load_cnt;
        pulse_done(8'h00);
        chk("R4 no load after last", load_cnt, base);
        chk("R4 tip idle", tip_n, 1);
        chk("R4 ack idle", ack, 1);
        chk("R4 dir input", sr_dir_out, 0);
        chk("R4 busy cleared", tx_busy, 0);
        tx_len = '0;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        repeat (20) @(negedge clk);
        chk("R10 zero length ignored busy", tx_busy, 0);
        chk("R10 zero length ignored load", load_cnt, base);
    endtask

    task automatic test_ignore();
        int lb = load_cnt;
        int rb = rxd_cnt;
        req_n = 1'b1;
        pulse_done(8'hEE);
        repeat (3) @(negedge clk);
        chk("R6 idle strobe ignored tip", tip_n, 1);
        chk("R6 idle strobe ignored ack", ack, 1);
        chk("R6 idle strobe ignored load", load_cnt, lb);
        chk("R6 idle strobe ignored rx", rxd_cnt, rb);
    endtask

    task automatic test_read();
        int rb = rxd_cnt;
        req_n = 1'b0;
        repeat (2) @(negedge clk);
        pulse_done(8'hEE);
        chk("R6 receive start tip", tip_n, 0);
        chk("R6 receive start dir", sr_dir_out, 0);
        chk("R6 receive start ack", ack, 1);
        pulse_done(8'h01);
        chk("R7 ack flip 1", ack, 0);
        pulse_done(8'hA1);
        chk("R7 ack flip 2", ack, 1);
        req_n = 1'b1;
        pulse_done(8'hA2);
        chk("R7 end tip", tip_n, 1);
        chk("R7 end ack", ack, 1);
        chk("R7 delivered", rxd_cnt, rb + 1);
        chk("R7 type", rx_type, 8'h01);
        chk("R7 len", rx_len, 2);
        chk("R7 no ovf", rx_ovf, 0);
        rx_rd_addr = '0;
        #1;
        chk("R7 payload 0", rx_rd_data, 8'hA1);
        rx_rd_addr = RXAW'(1);
        #1;
        chk("R7 payload 1", rx_rd_data, 8'hA2);
        repeat (5) @(negedge clk);
        chk("R11 len held", rx_len, 2);
        chk("R11 type held", rx_type, 8'h01);
    endtask

    task automatic test_collision();
        int w;
        int base;
        start_tx(8'h55, 8'h66, 8'h00, 2);
        wait_load(w);
        chk("R5 first byte", last_load, 8'h55);
        req_n = 1'b0;
        base = load_cnt;
        pulse_done(8'h00);
        chk("R5 abort tip", tip_n, 1);
        chk("R5 abort dir", sr_dir_out, 0);
        chk("R5 abort busy kept", tx_busy, 1);
        chk("R5 abort no load", load_cnt, base);
        wait_tip(1'b0, w);
        chk("R5 receive after abort", tip_n, 0);
        pulse_done(8'h02);
        req_n = 1'b1;
        pulse_done(8'h77);
        chk("R7 collided frame type", rx_type, 8'h02);
        chk("R7 collided frame len", rx_len, 1);
        wait_load(w);
        chk_ge("R9 gap before retry", w, GAP_CYC - 1);
        chk("R9 retry from byte0", last_load, 8'h55);
        pulse_done(8'h00);
        chk("R4 retry byte1", last_load, 8'h66);
        pulse_done(8'h00);
        chk("R4 retry done", tx_busy, 0);
    endtask

    task automatic test_gap_request();
        int w;
        int base;
        req_n = 1'b0;
        base = load_cnt;
        start_tx(8'h5A, 8'h00, 8'h00, 1);
        repeat (20) @(negedge clk);
        chk("R9 write held behind request", load_cnt, base);
        pulse_done(8'hEE);
        chk("R6 read first", tip_n, 0);
        req_n = 1'b1;
        pulse_done(8'h03);
        chk("R7 type only frame len", rx_len, 0);
        chk("R7 type only frame type", rx_type, 8'h03);
        repeat (5) @(negedge clk);
        req_n = 1'b0;
        repeat (GAP_CYC + 10) @(negedge clk);
        chk("R9 no write when request at gap end", load_cnt, base);
        chk("R9 lines idle at gap end", tip_n, 1);
        pulse_done(8'hEE);
        chk("R9 read cycle taken", tip_n, 0);
        req_n = 1'b1;
        pulse_done(8'h04);
        chk("R7 second frame type", rx_type, 8'h04);
        wait_load(w);
        chk_ge("R9 gap before deferred write", w, GAP_CYC - 1);
        chk("R9 deferred byte0", last_load, 8'h5A);
        pulse_done(8'h00);
        chk("R4 single byte done", tx_busy, 0);
    endtask

    task automatic test_overflow();
        req_n = 1'b0;
        repeat (2) @(negedge clk);
        pulse_done(8'hEE);
        for (int i = 0; i < RXD; i++) begin
            if (i == RXD - 1) chk("R8 still receiving before limit", tip_n, 0);
            pulse_done(8'(8'h30 + i));
        end
        chk("R8 limit ends frame", tip_n, 1);
        chk("R8 ovf flagged", rx_ovf, 1);
        chk("R8 len at limit", rx_len, RXD - 1);
        chk("R8 type", rx_type, 8'h30);
        pulse_done(8'hEE);
        chk("R8 next frame starts", tip_n, 0);
        req_n = 1'b1;
        pulse_done(8'h09);
        chk("R8 ovf only once", rx_ovf, 0);
        chk("R8 next len", rx_len, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        test_write();
        test_ignore();
        test_read();
        test_collision();
        test_gap_request();
        test_overflow();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule